// File: doc/BRIEF.md
# Variable-Length Instruction Byte Decoder

This block takes an instruction stream one byte per cycle, qualified by a valid strobe, and turns each instruction into a single decoded record. An instruction occupies one to six bytes. The decoder learns the total length from the upper nibble of the leading byte alone, so it needs no look-ahead and keeps no buffer beyond the instruction being gathered.

The record carries the operation class, the function selector, two register identifiers, a 32-bit constant built from little-endian bytes, the byte length and an illegal-instruction flag. The caller drives bytes when it has them. Cycles with the strobe low are skipped and leave the decoder where it was. An unknown leading byte is reported as a one-byte illegal record, and the next byte is taken as the start of a fresh instruction.

Top module: `insn_stream_decoder`

## Requirements
- R1: After reset, out_valid is low and the next accepted byte is treated as the leading byte of an instruction.
- R2: The upper nibble of the leading byte appears on out_icode and the lower nibble on out_ifun of that instruction's record.
- R3: out_len is decided by the upper nibble of the leading byte: 0x0, 0x1 and 0x9 give 1 byte; 0x2, 0x6, 0xA and 0xB give 2 bytes; 0x7 and 0x8 give 5 bytes; 0x3, 0x4 and 0x5 give 6 bytes.
- R4: For classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, the second byte is the register byte: its upper nibble goes to out_ra and its lower nibble goes to out_rb, both passed through unchanged.
- R5: For 1-byte and 5-byte instructions, and for illegal ones, out_ra and out_rb are both 8 (no register).
- R6: The constant bytes follow the register byte, or follow the leading byte directly for classes 0x7 and 0x8. The first constant byte lands in out_const[7:0] and the fourth in out_const[31:24]. out_const is zero for every record that has no constant bytes.
- R7: A leading byte is illegal when its upper nibble is above 0xB, or when its lower nibble exceeds the limit for its class (3 for class 0x6, 6 for class 0x7, 0 for all other classes). Such a byte produces a record with out_illegal=1, out_len=1, out_ra=out_rb=8 and out_const=0. The byte that follows is decoded as a new leading byte.
- R8: out_valid is high for exactly one cycle per instruction: the cycle after the edge that accepts the instruction's last byte. Cycles with in_valid low, before or between bytes, are not counted as bytes and do not raise out_valid.
- R9: Instructions sent back to back with no idle cycles are each decoded, with out_valid high on consecutive cycles when they are consecutive single-byte instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte carries a byte this cycle |
| in_byte | input | 8 | Next instruction byte |
| out_valid | output | 1 | Decoded record valid (one-cycle pulse) |
| out_icode | output | 4 | Operation class nibble |
| out_ifun | output | 4 | Function selector nibble |
| out_ra | output | 4 | First register identifier, 8 when absent |
| out_rb | output | 4 | Second register identifier, 8 when absent |
| out_const | output | 32 | Little-endian assembled constant, 0 when absent |
| out_len | output | 3 | Instruction length in bytes |
| out_illegal | output | 1 | Leading byte was not a legal instruction |

## Verification
Every record is due exactly one clock edge after the edge that accepts the instruction's last byte. For an illegal byte or a single-byte instruction, that is the edge accepting the leading byte itself. The bench drives each byte on a falling edge. It checks the whole record on the falling edge that follows the accepting rising edge, then checks that out_valid has dropped one cycle later. At every intermediate falling edge, including idle gaps inserted between bytes, it confirms that out_valid stays low. The back-to-back streams are sampled on every falling edge, so a record that comes a cycle early or late shows up as a wrong class or a missing pulse.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

   localparam int NIB_W = 4;

   localparam logic [NIB_W-1:0] CLS_NOP   = 4'h0;
   localparam logic [NIB_W-1:0] CLS_HALT  = 4'h1;
   localparam logic [NIB_W-1:0] CLS_RRMOV = 4'h2;
   localparam logic [NIB_W-1:0] CLS_IRMOV = 4'h3;
   localparam logic [NIB_W-1:0] CLS_RMMOV = 4'h4;
   localparam logic [NIB_W-1:0] CLS_MRMOV = 4'h5;
   localparam logic [NIB_W-1:0] CLS_ALU   = 4'h6;
   localparam logic [NIB_W-1:0] CLS_JUMP  = 4'h7;
   localparam logic [NIB_W-1:0] CLS_CALL  = 4'h8;
   localparam logic [NIB_W-1:0] CLS_RET   = 4'h9;
   localparam logic [NIB_W-1:0] CLS_PUSH  = 4'hA;
   localparam logic [NIB_W-1:0] CLS_POP   = 4'hB;

   // highest defined class
   localparam logic [NIB_W-1:0] CLS_LAST  = CLS_POP;

   function automatic logic cls_has_reg(input logic [NIB_W-1:0] cls);
      return (cls inside {CLS_RRMOV, CLS_IRMOV, CLS_RMMOV, CLS_MRMOV,
                          CLS_ALU, CLS_PUSH, CLS_POP});
   endfunction

   function automatic logic cls_has_const(input logic [NIB_W-1:0] cls);
      return (cls inside {CLS_IRMOV, CLS_RMMOV, CLS_MRMOV, CLS_JUMP, CLS_CALL});
   endfunction

   function automatic logic [NIB_W-1:0] cls_fun_limit(input logic [NIB_W-1:0] cls);
      case (cls)
         CLS_ALU:  return 4'd3;
         CLS_JUMP: return 4'd6;
         default:  return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/insn_head_classify.sv
module insn_head_classify
   import insn_dec_pkg::*;
#(
   parameter int CONST_BYTES = 4,
   localparam int LEN_W = $clog2(CONST_BYTES + 3)
)(
   input  logic [2*NIB_W-1:0] head,
   output logic [LEN_W-1:0]   len,
   output logic               has_reg,
   output logic               illegal
);

   localparam logic [LEN_W-1:0] LEN_ONE   = 1;
   localparam logic [LEN_W-1:0] LEN_CONST = LEN_W'(CONST_BYTES);

   logic [NIB_W-1:0] cls;
   logic [NIB_W-1:0] fun;
   logic             has_const;

   assign cls = head[2*NIB_W-1:NIB_W];
   assign fun = head[NIB_W-1:0];

   always_comb begin
      illegal   = (cls > CLS_LAST) || (fun > cls_fun_limit(cls));
      has_reg   = cls_has_reg(cls);
      has_const = cls_has_const(cls);
      if (illegal) begin
         len = LEN_ONE;
      end else begin
         len = LEN_ONE + (has_reg ? LEN_ONE : '0) + (has_const ? LEN_CONST : '0);
      end
   end

endmodule

// File: rtl/le_const_assembler.sv
module le_const_assembler #(
   parameter int CONST_BYTES = 4,
   localparam int CONST_W = 8 * CONST_BYTES
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               shift_en,
   input  logic [7:0]         din,
   output logic [CONST_W-1:0] dout
);

   // Bytes enter at the top lane and move down; after CONST_BYTES shifts
   // the first byte received sits in lane 0 (little-endian order).
   for (genvar i = 0; i < CONST_BYTES; i++) begin : g_lane
      logic [7:0] next_byte;
      if (i == CONST_BYTES - 1) begin : g_top
         assign next_byte = din;
      end else begin : g_mid
         assign next_byte = dout[8*(i+1) +: 8];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            dout[8*i +: 8] <= '0;
         end else if (shift_en) begin
            dout[8*i +: 8] <= next_byte;
         end
      end
   end

endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
   import insn_dec_pkg::*;
#(
   parameter int               CONST_BYTES = 4,
   parameter logic [NIB_W-1:0] REG_NONE    = 4'h8,
   localparam int LEN_W   = $clog2(CONST_BYTES + 3),
   localparam int CONST_W = 8 * CONST_BYTES
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_byte,
   output logic               out_valid,
   output logic [NIB_W-1:0]   out_icode,
   output logic [NIB_W-1:0]   out_ifun,
   output logic [NIB_W-1:0]   out_ra,
   output logic [NIB_W-1:0]   out_rb,
   output logic [CONST_W-1:0] out_const,
   output logic [LEN_W-1:0]   out_len,
   output logic               out_illegal
);

   if (CONST_BYTES < 1 || CONST_BYTES > 8) begin : g_bad_const_bytes
      $error("CONST_BYTES must lie in 1..8");
   end

   localparam logic [LEN_W-1:0] LEN_ONE = 1;

   // classification of the byte in flight
   logic [LEN_W-1:0] head_len;
   logic             head_has_reg;
   logic             head_illegal;

   insn_head_classify #(.CONST_BYTES(CONST_BYTES)) u_classify (
      .head    (in_byte),
      .len     (head_len),
      .has_reg (head_has_reg),
      .illegal (head_illegal)
   );

   // gathering state
   logic             busy_q;
   logic [LEN_W-1:0] pos_q;
   logic [LEN_W-1:0] len_q;
   logic             hreg_q;

   logic take_head;
   logic take_body;
   logic body_is_reg;
   logic body_is_last;
   logic head_done;

   assign take_head    = in_valid && !busy_q;
   assign take_body    = in_valid && busy_q;
   assign body_is_reg  = hreg_q && (pos_q == LEN_ONE);
   assign body_is_last = (pos_q + LEN_ONE) == len_q;
   assign head_done    = head_illegal || (head_len == LEN_ONE);

   le_const_assembler #(.CONST_BYTES(CONST_BYTES)) u_const (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (take_head),
      .shift_en (take_body && !body_is_reg),
      .din      (in_byte),
      .dout     (out_const)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         pos_q       <= '0;
         len_q       <= '0;
         hreg_q      <= 1'b0;
         out_valid   <= 1'b0;
         out_icode   <= '0;
         out_ifun    <= '0;
         out_ra      <= REG_NONE;
         out_rb      <= REG_NONE;
         out_len     <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (take_head) begin
            out_icode   <= in_byte[2*NIB_W-1:NIB_W];
            out_ifun    <= in_byte[NIB_W-1:0];
            out_ra      <= REG_NONE;
            out_rb      <= REG_NONE;
            out_len     <= head_len;
            out_illegal <= head_illegal;
            if (head_done) begin
               out_valid <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               pos_q  <= LEN_ONE;
               len_q  <= head_len;
               hreg_q <= head_has_reg;
            end
         end else if (take_body) begin
            if (body_is_reg) begin
               out_ra <= in_byte[2*NIB_W-1:NIB_W];
               out_rb <= in_byte[NIB_W-1:0];
            end
            pos_q <= pos_q + LEN_ONE;
            if (body_is_last) begin
               busy_q    <= 1'b0;
               out_valid <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/insn_stream_decoder_chk.sv
module insn_stream_decoder_chk #(
   parameter int         CONST_BYTES = 4,
   parameter logic [3:0] REG_NONE    = 4'h8,
   localparam int LEN_W   = $clog2(CONST_BYTES + 3),
   localparam int CONST_W = 8 * CONST_BYTES
)(
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               out_valid,
   input logic [3:0]         out_icode,
   input logic [3:0]         out_ifun,
   input logic [3:0]         out_ra,
   input logic [3:0]         out_rb,
   input logic [CONST_W-1:0] out_const,
   input logic [LEN_W-1:0]   out_len,
   input logic               out_illegal
);

   function automatic int legal_len(input logic [3:0] c);
      case (c)
         4'h0, 4'h1, 4'h9:       return 1;
         4'h2, 4'h6, 4'hA, 4'hB: return 2;
         4'h7, 4'h8:             return 1 + CONST_BYTES;
         default:                return 2 + CONST_BYTES;
      endcase
   endfunction

   // R8: a record only follows a cycle in which a byte was accepted
   assert_record_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R3: reported length matches the class of a legal record
   assert_len_by_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal) |-> (int'(out_len) == legal_len(out_icode)));

   // R5: formats without a register byte report the no-register ID
   assert_no_reg_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_illegal || out_icode inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9}))
      |-> (out_ra == REG_NONE && out_rb == REG_NONE));

   // R7: unknown classes and out-of-range functions are flagged, as one byte
   assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_icode > 4'hB || (out_icode == 4'h6 && out_ifun > 4'd3)
                     || (out_icode == 4'h7 && out_ifun > 4'd6)))
      |-> (out_illegal && out_len == 1));

   // R6: records without constant bytes carry a zero constant
   assert_const_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len <= 2) |-> (out_const == '0));

endmodule

bind insn_stream_decoder insn_stream_decoder_chk #(
   .CONST_BYTES (CONST_BYTES),
   .REG_NONE    (REG_NONE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_icode   (out_icode),
   .out_ifun    (out_ifun),
   .out_ra      (out_ra),
   .out_rb      (out_rb),
   .out_const   (out_const),
   .out_len     (out_len),
   .out_illegal (out_illegal)
);

// File: tb/insn_stream_decoder_bench.sv
`timescale 1ns/1ps
module insn_stream_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        out_valid;
   logic [3:0]  out_icode, out_ifun, out_ra, out_rb;
   logic [31:0] out_const;
   logic [2:0]  out_len;
   logic        out_illegal;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   insn_stream_decoder u_insn_stream_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_icode(out_icode), .out_ifun(out_ifun),
      .out_ra(out_ra), .out_rb(out_rb), .out_const(out_const),
      .out_len(out_len), .out_illegal(out_illegal)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   function automatic logic bad_byte(input logic [7:0] b);
      logic [3:0] lim;
      lim = (b[7:4] == 4'h6) ? 4'd3 : (b[7:4] == 4'h7) ? 4'd6 : 4'd0;
      return (b[7:4] > 4'hB) || (b[3:0] > lim);
   endfunction

   function automatic logic [2:0] exp_len(input logic [7:0] b);
      if (bad_byte(b)) return 3'd1;
      case (b[7:4])
         4'h0, 4'h1, 4'h9:       return 3'd1;
         4'h2, 4'h6, 4'hA, 4'hB: return 3'd2;
         4'h7, 4'h8:             return 3'd5;
         default:                return 3'd6;
      endcase
   endfunction

   // Sends n bytes (byte i in bits [8i+7:8i]) with gap idle cycles between
   // them, then checks the record and the one-cycle pulse.
   task automatic send_and_check(input string tag, input logic [47:0] bytes, input int n,
                                 input int gap, input logic [3:0] e_ra, input logic [3:0] e_rb,
                                 input logic [31:0] e_const);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i > 0) chk({tag, " R8 no early record"}, 32'(out_valid), 32'd0);
         in_valid = 1'b1;
         in_byte  = bytes[8*i +: 8];
         if (i < n - 1) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               in_valid = 1'b0;
               chk({tag, " R8 idle gap"}, 32'(out_valid), 32'd0);
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " R8 record due"}, 32'(out_valid), 32'd1);
      chk({tag, " R2 icode"}, 32'(out_icode), 32'(bytes[7:4]));
      chk({tag, " R2 ifun"}, 32'(out_ifun), 32'(bytes[3:0]));
      chk({tag, " R3 len"}, 32'(out_len), 32'(exp_len(bytes[7:0])));
      chk({tag, " R7 illegal"}, 32'(out_illegal), 32'(bad_byte(bytes[7:0])));
      chk({tag, " R4 ra"}, 32'(out_ra), 32'(e_ra));
      chk({tag, " R4 rb"}, 32'(out_rb), 32'(e_rb));
      chk({tag, " R6 const"}, out_const, e_const);
      @(negedge clk);
      chk({tag, " R8 pulse ends"}, 32'(out_valid), 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 valid low in reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid low after reset", 32'(out_valid), 32'd0);
   endtask

   task automatic t_single_byte();
      send_and_check("nop R5", 48'h00, 1, 0, 4'h8, 4'h8, 32'h0);
      send_and_check("halt", 48'h10, 1, 0, 4'h8, 4'h8, 32'h0);
      send_and_check("ret", 48'h90, 1, 0, 4'h8, 4'h8, 32'h0);
   endtask

   task automatic t_two_byte();
      send_and_check("add R4", 48'h0660, 2, 0, 4'h0, 4'h6, 32'h0);
      send_and_check("xor", 48'h7163, 2, 0, 4'h7, 4'h1, 32'h0);
      send_and_check("rrmove", 48'h4320, 2, 1, 4'h4, 4'h3, 32'h0);
      send_and_check("push", 48'h28A0, 2, 0, 4'h2, 4'h8, 32'h0);
   endtask

   task automatic t_six_byte();
      send_and_check("irmove R6", 48'h0000abcd8230, 6, 0, 4'h8, 4'h2, 32'h0000abcd);
      send_and_check("mrmove", 48'hfffffff41550, 6, 0, 4'h1, 4'h5, 32'hfffffff4);
      // constant must be cleared for a following short record
      send_and_check("pop after const R6", 48'h38B0, 2, 0, 4'h3, 4'h8, 32'h0);
   endtask

   task automatic t_five_byte();
      send_and_check("jne R5", 48'h1234567874, 5, 0, 4'h8, 4'h8, 32'h12345678);
      send_and_check("call", 48'h0000002880, 5, 0, 4'h8, 4'h8, 32'h00000028);
   endtask

   task automatic t_gaps();
      send_and_check("rmmove gaps R8", 48'h0000041c6440, 6, 2, 4'h6, 4'h4, 32'h0000041c);
      send_and_check("jg gaps", 48'h8899aabb76, 5, 3, 4'h8, 4'h8, 32'h8899aabb);
   endtask

   task automatic t_illegal();
      send_and_check("class C R7", 48'h00C0, 1, 0, 4'h8, 4'h8, 32'h0);
      send_and_check("alu fun 4 R7", 48'h64, 1, 0, 4'h8, 4'h8, 32'h0);
      send_and_check("jump fun 7 R7", 48'h77, 1, 0, 4'h8, 4'h8, 32'h0);
      send_and_check("irmove fun 1 R7", 48'h31, 1, 0, 4'h8, 4'h8, 32'h0);
   endtask

   // R9 and R7 resync: continuous stream C5 10 64 20 43
   task automatic t_back_to_back();
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'hC5;
      @(negedge clk);
      chk("R7 resync illegal valid", 32'(out_valid), 32'd1);
      chk("R7 resync illegal flag", 32'(out_illegal), 32'd1);
      in_byte = 8'h10;
      @(negedge clk);
      chk("R9 halt valid", 32'(out_valid), 32'd1);
      chk("R9 halt icode", 32'(out_icode), 32'h1);
      chk("R9 halt legal", 32'(out_illegal), 32'd0);
      in_byte = 8'h64;
      @(negedge clk);
      chk("R9 alu fun 4 flagged", 32'(out_illegal), 32'd1);
      chk("R9 alu fun 4 valid", 32'(out_valid), 32'd1);
      in_byte = 8'h20;
      @(negedge clk);
      chk("R9 mid rrmove no record", 32'(out_valid), 32'd0);
      in_byte = 8'h43;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 rrmove valid", 32'(out_valid), 32'd1);
      chk("R9 rrmove ra", 32'(out_ra), 32'h4);
      chk("R9 rrmove rb", 32'(out_rb), 32'h3);
      chk("R9 rrmove len", 32'(out_len), 32'd2);
      @(negedge clk);
      chk("R9 stream idle", 32'(out_valid), 32'd0);
   endtask

   initial begin
      t_reset();
      t_single_byte();
      t_two_byte();
      t_six_byte();
      t_five_byte();
      t_gaps();
      t_illegal();
      t_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule